// File: doc/BRIEF.md
# Machine Cycle Generator with Reset Qualifier

This block turns the oscillator clock into machine cycles for a small 8-bit controller core. A phase counter steps through twelve oscillator periods per machine cycle. A one-clock strobe marks the last period of each cycle, so the core can advance its state at that point. At a 12 MHz clock one machine cycle is therefore one microsecond.

The block also filters the external reset pin. That pin is active high, asynchronous, and held low in normal running. The block first brings the pin into the clock domain through a synchroniser. It then times how long the pin has stayed high. The core reset is raised only after the pin has been high for two whole machine cycles, which is 24 oscillator clocks. A shorter pulse is ignored and leaves the phase counter running undisturbed.

While the reset is active and the pin stays high, the phase counter is parked at zero. Once the pin falls, the counter restarts from zero. The core reset drops on the boundary that closes that first complete machine cycle, so the core always leaves reset aligned to phase zero.

Top module: `mcycle_rst_qual`

## Requirements
- R1: Outside the parked state, `phase` advances by one per clock through 0..11 and wraps from 11 to 0.
- R2: `cycle_strobe` is a single-clock pulse that is high exactly while `phase` is 11.
- R3: The pin passes through a two-flop synchroniser. A pin level sampled at clock edge k first influences the qualifier at edge k+2.
- R4: If the pin is sampled high on 24 consecutive edges, starting at edge k, then `core_rst` goes high after edge k+25.
- R5: A high pulse sampled on 23 or fewer consecutive edges never raises `core_rst`. It also leaves `phase` counting normally.
- R6: While `core_rst` is high and the synchronised pin is high, `phase` reads 0 and `cycle_strobe` stays low.
- R7: `core_rst` stays high for as long as the pin stays high. If the pin is first sampled low at edge m, and is not sampled high again, then `core_rst` falls after edge m+13.
- R8: On the edge where `core_rst` falls, `phase` returns to 0. That edge ends a complete machine cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_osc | input | 1 | Oscillator clock |
| rst_pin | input | 1 | Asynchronous external reset request, active high |
| phase | output | 4 | Oscillator period within the machine cycle, 0..11 |
| cycle_strobe | output | 1 | High for one clock on phase 11 |
| core_rst | output | 1 | Qualified internal reset, active high |

## Verification
Two events can land on the same clock edge:
- the qualifier reaching its 24-clock threshold, and
- the machine-cycle strobe.

Likewise, the pin can return high in the very cycle the release boundary arrives.

Random pin runs are used to provoke both collisions. Their lengths spread around the 23/24-sample threshold, and they start at arbitrary phases, so both events fall on every possible phase position. A cycle-by-cycle bench model judges the outcome, which must satisfy two conditions:
- the reset wins any tie, and parks the phase at zero on the next edge;
- a release happens only on an edge where the phase wraps.

Directed runs pin down the exact edge counts of 23, 24 and 13 clocks.

// File: rtl/mcr_pkg.sv
package mcr_pkg;
  // Next phase value inside a machine cycle of n_clks periods.
  function automatic int unsigned phase_after(int unsigned cur, int unsigned n_clks);
    return (cur + 1 >= n_clks) ? 0 : cur + 1;
  endfunction

  // Number of synchronised high samples needed before reset is accepted.
  function automatic int unsigned hold_limit(int unsigned cycles, int unsigned n_clks);
    return cycles * n_clks;
  endfunction
endpackage

// File: rtl/mcr_sync.sv
module mcr_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic d_async,
  output logic q_sync
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) chain[0] <= d_async;

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk) chain[i] <= chain[i-1];
  end

  assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/mcr_phase_gen.sv
module mcr_phase_gen #(
  parameter int CLKS = 12,
  localparam int W = $clog2(CLKS)
) (
  input  logic         clk,
  input  logic         park,
  output logic [W-1:0] phase_o,
  output logic         strobe_o
);
  localparam logic [W-1:0] LAST = W'(CLKS - 1);

  logic [W-1:0] ph;

  always_ff @(posedge clk) begin
    if (park) ph <= '0;
    else      ph <= W'(mcr_pkg::phase_after(int'(ph), CLKS));
  end

  assign phase_o  = ph;
  assign strobe_o = (ph == LAST);

  // R1: free-running step outside the parked state
  a_r1_step: assert property (@(posedge clk) disable iff (park)
    (ph != LAST) |=> (ph == $past(ph) + W'(1)));
  // R8: wrap at the end of the cycle
  a_r8_wrap: assert property (@(posedge clk) disable iff (park)
    strobe_o |=> (ph == '0));
  // R2: strobe never lasts two clocks
  a_r2_single: assert property (@(posedge clk) strobe_o |=> !strobe_o);
endmodule

// File: rtl/mcr_hold_qual.sv
module mcr_hold_qual #(
  parameter int LIMIT = 24,
  localparam int CW = $clog2(LIMIT + 1)
) (
  input  logic clk,
  input  logic pin_s,
  input  logic cyc_end,
  output logic core_rst_o
);
  logic [CW-1:0] hi_cnt;
  logic          qualify;
  logic          release_now;
  logic          rst_q;

  assign qualify     = pin_s && (hi_cnt == CW'(LIMIT - 1));
  assign release_now = rst_q && !pin_s && cyc_end;

  always_ff @(posedge clk) begin
    if (!pin_s)                  hi_cnt <= '0;
    else if (hi_cnt != CW'(LIMIT)) hi_cnt <= hi_cnt + CW'(1);
  end

  always_ff @(posedge clk) begin
    if (qualify)          rst_q <= 1'b1;
    else if (release_now) rst_q <= 1'b0;
  end

  assign core_rst_o = rst_q;

  // R5: a low synchronised sample restarts timing, so no rise can follow it
  a_r5_no_early_rise: assert property (@(posedge clk)
    !pin_s |=> !$rose(rst_q));
  // R7: reset held while the synchronised pin is high
  a_r7_hold_high: assert property (@(posedge clk) disable iff (!pin_s)
    rst_q |=> rst_q);
  // R7: release only at a machine-cycle end
  a_r7_release_edge: assert property (@(posedge clk)
    $fell(rst_q) |-> $past(cyc_end));
endmodule

// File: rtl/mcycle_rst_qual.sv
module mcycle_rst_qual #(
  parameter int CLKS_PER_CYCLE = 12,
  parameter int HOLD_CYCLES    = 2,
  parameter int SYNC_STAGES    = 2,
  localparam int PW = $clog2(CLKS_PER_CYCLE)
) (
  input  logic          clk_osc,
  input  logic          rst_pin,
  output logic [PW-1:0] phase,
  output logic          cycle_strobe,
  output logic          core_rst
);
  localparam int LIMIT = mcr_pkg::hold_limit(HOLD_CYCLES, CLKS_PER_CYCLE);

  logic pin_sync;
  logic phase_park;
  logic strobe_w;
  logic rst_w;

  mcr_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk_osc), .d_async(rst_pin), .q_sync(pin_sync)
  );

  assign phase_park = rst_w && pin_sync;

  mcr_phase_gen #(.CLKS(CLKS_PER_CYCLE)) u_phase (
    .clk(clk_osc), .park(phase_park), .phase_o(phase), .strobe_o(strobe_w)
  );

  mcr_hold_qual #(.LIMIT(LIMIT)) u_qual (
    .clk(clk_osc), .pin_s(pin_sync), .cyc_end(strobe_w), .core_rst_o(rst_w)
  );

  assign cycle_strobe = strobe_w;
  assign core_rst     = rst_w;

  // R6: parked at phase zero while reset and pin are both high
  a_r6_parked: assert property (@(posedge clk_osc) disable iff (!pin_sync)
    rst_w |=> (phase == '0) && !cycle_strobe);
endmodule

// File: tb/sim_mcycle_rst_qual.sv
module sim_mcycle_rst_qual;
  logic       clk = 1'b0;
  logic       pin = 1'b0;
  logic [3:0] phase;
  logic       cycle_strobe;
  logic       core_rst;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  mcycle_rst_qual u0 (
    .clk_osc(clk), .rst_pin(pin), .phase(phase),
    .cycle_strobe(cycle_strobe), .core_rst(core_rst)
  );

  // Reference model built from the requirements: the pin is seen two edges
  // late, 24 seen-high samples qualify, release waits for the cycle end.
  logic       seen1 = 1'b0, seen2 = 1'b0;
  int         run = 0;
  logic       m_rst = 1'b0;
  int         m_ph = 0;
  bit         m_valid = 1'b0;

  function automatic int exp_next_phase(int p);
    return (p + 1) % 12;
  endfunction

  always @(posedge clk) begin
    int  nrun;
    bit  rise, fall;
    nrun = seen2 ? ((run >= 24) ? 24 : run + 1) : 0;
    rise = !m_rst && seen2 && (nrun == 24) && (run == 23);
    fall = m_rst && !seen2 && (m_ph == 11);
    if (m_rst && seen2) m_ph <= 0;
    else                m_ph <= exp_next_phase(m_ph);
    if (rise) begin m_rst <= 1'b1; m_valid <= 1'b1; end
    else if (fall) m_rst <= 1'b0;
    run   <= nrun;
    seen1 <= pin;
    seen2 <= seen1;
  end

  task automatic chk(bit ok, string req, int act, int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, expv, $time);
    end
  endtask

  always @(negedge clk) begin
    if (m_valid && !done) begin
      chk(core_rst == m_rst, "R4/R7 core_rst vs model", core_rst, m_rst);
      chk(phase == m_ph, "R1/R6 phase vs model", phase, m_ph);
      chk(cycle_strobe == (m_ph == 11), "R2 strobe vs model", cycle_strobe, m_ph == 11);
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  // Drive the pin high for n samples, low afterwards; return edge index of
  // first core_rst rise (or -1) within span edges.
  task automatic pulse(int n, int span, output int rise_at);
    int prev_rst;
    rise_at  = -1;
    @(negedge clk);
    prev_rst = core_rst;
    pin = 1'b1;
    for (int i = 0; i < span; i++) begin
      @(posedge clk);
      @(negedge clk);
      if (!prev_rst && core_rst && rise_at < 0) rise_at = i;
      prev_rst = core_rst;
      if (i == n - 1) pin = 1'b0;
    end
    pin = 1'b0;
  endtask

  initial begin
    int r;
    int p0;
    void'($urandom(32'h0051_0C12));
    pin = 1'b0;
    repeat (5) @(negedge clk);
    // power-on style reset: 30 high samples
    pulse(30, 32, r);
    chk(core_rst == 1'b1, "R4 reset state core_rst", core_rst, 1);
    chk(phase == 4'd0, "R6 reset state phase", phase, 0);
    chk(cycle_strobe == 1'b0, "R6 reset state strobe", cycle_strobe, 0);
    pin = 1'b1;
    repeat (10) @(negedge clk);

    // R7/R8 directed release: first low sample at edge m
    pin = 1'b0;
    for (int i = 0; i <= 13; i++) begin
      @(posedge clk);
      @(negedge clk);
      chk(core_rst == (i < 13), "R7 release timing", core_rst, i < 13);
      if (i >= 2 && i <= 12) chk(phase == 4'(i - 1), "R3 phase restarts two edges late", phase, i - 1);
      if (i == 13) chk(phase == 4'd0, "R8 phase zero at release", phase, 0);
    end

    // R5: 23 samples never qualify, phase keeps counting
    repeat (7) @(negedge clk);
    p0 = phase;
    pulse(23, 40, r);
    chk(r == -1, "R5 23-sample pulse ignored", r, -1);
    chk(core_rst == 1'b0, "R5 core_rst after short pulse", core_rst, 0);
    chk(phase == 4'((p0 + 41) % 12), "R5 phase undisturbed", phase, (p0 + 41) % 12);

    // R4: 24 samples qualify, rise after edge k+25
    pulse(24, 30, r);
    chk(r == 25, "R4 24-sample rise edge", r, 25);

    // release then random runs around the threshold
    repeat (20) @(negedge clk);
    for (int s = 0; s < 120; s++) begin
      int len;
      len = (s % 3 == 0) ? int'($urandom_range(20, 28)) : int'($urandom_range(1, 45));
      pin = (s % 2 == 0);
      repeat (len) @(negedge clk);
    end
    pin = 1'b0;
    repeat (30) @(negedge clk);
    chk(core_rst == 1'b0, "R7 released after random run", core_rst, 0);
    finish_run();
  end
endmodule